// File: doc/BRIEF.md
# Parallel Flash Read Response Unit

This block is the read half of a parallel NOR flash model that uses the classic unlock-cycle command set. On each read strobe it looks at the command state reported by a separate write sequencer and decides what the bus sees. In plain read mode it returns array bytes, packed into a bus word in either byte order. In identifier mode it returns one of four configured identifier words or a protection flag. While a program or erase operation runs it returns an embedded-operation status byte. In query mode it returns a byte from an external query table.

The flash array and the query table are outside the block. It drives a word-aligned array address and a table index, and both are expected to answer combinationally. The block owns the status byte. The write sequencer loads it through a load strobe, and every status read flips bit 6 so that software polling sees a toggle. A command-state code the block does not recognise is served as a plain array read, and the block raises a one-cycle request that the sequencer return to read mode.

Top module: `flash_read_resp`

## Requirements
- R1: Read data and `rd_valid` appear exactly one clock after `rd_en` is sampled high. `rd_valid` is low in any cycle that follows a cycle without a read, and `rd_data` then holds its last value.
- R2: The lookup index is the low 8 bits of `rd_addr` shifted right by log2(BUS_BYTES). With BUS_BYTES=2, address 0x1C gives index 0x0E, and address bits above bit 7 have no effect on identifier or query reads.
- R3: With command state 0 (read) or 1 (between the two unlock sequences of an erase), a read returns the array word at the aligned address. `arr_addr` is `rd_addr` with its low log2(BUS_BYTES) bits cleared.
- R4: Lane i of `arr_bytes` holds the byte at `arr_addr`+i. With `big_endian`=0, lane i goes to data bits [8i+7:8i]. With `big_endian`=1, lane 0 goes to the most significant byte.
- R5: With command state 2 (identifier), index 0 returns `id_mfr`, index 1 returns `id_dev`, and index 2 returns zero, meaning no sector is protected. Identifiers are zero-extended to the data width.
- R6: In identifier mode, index 0x0E returns `id_ext2` and index 0x0F returns `id_ext3`, unless that word's low byte is 0xFF, in which case the array word is returned. Every other index also returns the array word.
- R7: With command state 3, 4 or 5 (program, chip erase, sector erase), a read returns the stored status byte, zero-extended. After the read, bit 6 of the stored status is inverted. Reads in any other state leave the status unchanged.
- R8: `st_load` replaces the stored status with `st_load_val` on the next edge. A load takes priority over a toggle in the same cycle.
- R9: With command state 6 (query), an index greater than QRY_LEN returns zero. Any other index returns `qry_data`, zero-extended, with `qry_addr` equal to the index.
- R10: A read with command state 7, which is unrecognised, returns the array word as in read mode. It raises `seq_reset_req` for the single cycle in which that data is valid.
- R11: While `rst` is high, and in the cycle after it, `rd_data`, `rd_valid` and `seq_reset_req` are zero, and the stored status resets to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Byte address of the read |
| cmd_state | input | 3 | Command state from the write sequencer |
| big_endian | input | 1 | Byte order for array words |
| id_mfr | input | 16 | Manufacturer identifier |
| id_dev | input | 16 | Device identifier |
| id_ext2 | input | 16 | Extended identifier at index 0x0E |
| id_ext3 | input | 16 | Extended identifier at index 0x0F |
| st_load | input | 1 | Load strobe for the status byte |
| st_load_val | input | 8 | Status value to load |
| arr_addr | output | ADDR_W | Word-aligned array address |
| arr_bytes | input | 8*BUS_BYTES | Array bytes, lane i at arr_addr+i |
| qry_addr | output | 8 | Query table index |
| qry_data | input | 8 | Query table byte |
| rd_data | output | 8*BUS_BYTES | Registered read data |
| rd_valid | output | 1 | Read data valid |
| seq_reset_req | output | 1 | Request to return the sequencer to read mode |

## Verification
Most internal faults show up on the very next `rd_data` after a read, because the output register sits one clock behind the strobe. A wrong index shift, a swapped lane order, or a misrouted identifier gives the wrong word in the cycle where `rd_valid` rises. A status bit that does not toggle, or that toggles on a read in the wrong state, hides until the next status poll. The bench therefore runs status reads back to back and puts identifier reads between them. A wrong decision about unrecognised codes shows on `seq_reset_req` in that same valid cycle.

// File: rtl/frr_pkg.sv
package frr_pkg;

  typedef enum logic [2:0] {
    CS_READ         = 3'd0,
    CS_ERASE_SETUP  = 3'd1,
    CS_AUTOSEL      = 3'd2,
    CS_PROGRAM      = 3'd3,
    CS_CHIP_ERASE   = 3'd4,
    CS_SECTOR_ERASE = 3'd5,
    CS_QUERY        = 3'd6
  } cmd_state_e;

  typedef enum logic [2:0] {
    SRC_ARRAY  = 3'd0,
    SRC_ID     = 3'd1,
    SRC_ZERO   = 3'd2,
    SRC_STATUS = 3'd3,
    SRC_QUERY  = 3'd4
  } rd_src_e;

  localparam logic [7:0] IDX_MFR  = 8'h00;
  localparam logic [7:0] IDX_DEV  = 8'h01;
  localparam logic [7:0] IDX_PROT = 8'h02;
  localparam logic [7:0] IDX_EXT2 = 8'h0E;
  localparam logic [7:0] IDX_EXT3 = 8'h0F;

  localparam logic [7:0] TOGGLE_MASK = 8'h40;

endpackage

// File: rtl/frr_offset.sv
module frr_offset #(
  parameter int BUS_BYTES = 2,
  parameter int ADDR_W    = 16
) (
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        word_idx,
  output logic [ADDR_W-1:0] word_addr
);
  localparam int SH = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 0;

  // Lookup index: low byte of the address in units of bus words (R2)
  assign word_idx = rd_addr[7:0] >> SH;

  generate
    if (SH == 0) begin : g_byte
      assign word_addr = rd_addr;
    end else begin : g_wide
      assign word_addr = {rd_addr[ADDR_W-1:SH], {SH{1'b0}}};
    end
  endgenerate

endmodule

// File: rtl/frr_lane_order.sv
module frr_lane_order #(
  parameter int BUS_BYTES = 2
) (
  input  logic [8*BUS_BYTES-1:0] lanes,
  input  logic                   big_endian,
  output logic [8*BUS_BYTES-1:0] word
);
  logic [8*BUS_BYTES-1:0] le_word;
  logic [8*BUS_BYTES-1:0] be_word;

  // Lane i is the byte at base+i; place it by byte order (R4)
  generate
    for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
      assign le_word[8*i +: 8]               = lanes[8*i +: 8];
      assign be_word[8*(BUS_BYTES-1-i) +: 8] = lanes[8*i +: 8];
    end
  endgenerate

  assign word = big_endian ? be_word : le_word;

endmodule

// File: rtl/frr_decode.sv
module frr_decode
  import frr_pkg::*;
#(
  parameter logic [7:0] QRY_LEN = 8'h52
) (
  input  logic [2:0]  cmd_state,
  input  logic [7:0]  word_idx,
  input  logic [15:0] id_mfr,
  input  logic [15:0] id_dev,
  input  logic [15:0] id_ext2,
  input  logic [15:0] id_ext3,
  output rd_src_e     src,
  output logic [15:0] id_val,
  output logic        unknown
);

  always_comb begin
    src     = SRC_ARRAY;
    id_val  = 16'h0000;
    unknown = 1'b0;
    case (cmd_state)
      CS_READ, CS_ERASE_SETUP: src = SRC_ARRAY;
      CS_AUTOSEL: begin
        case (word_idx)
          IDX_MFR: begin
            src    = SRC_ID;
            id_val = id_mfr;
          end
          IDX_DEV: begin
            src    = SRC_ID;
            id_val = id_dev;
          end
          IDX_PROT: src = SRC_ZERO;
          IDX_EXT2: begin
            if (id_ext2[7:0] != 8'hFF) begin
              src    = SRC_ID;
              id_val = id_ext2;
            end
          end
          IDX_EXT3: begin
            if (id_ext3[7:0] != 8'hFF) begin
              src    = SRC_ID;
              id_val = id_ext3;
            end
          end
          default: src = SRC_ARRAY;
        endcase
      end
      CS_PROGRAM, CS_CHIP_ERASE, CS_SECTOR_ERASE: src = SRC_STATUS;
      CS_QUERY: src = (word_idx > QRY_LEN) ? SRC_ZERO : SRC_QUERY;
      default: begin
        src     = SRC_ARRAY;
        unknown = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/frr_status.sv
module frr_status
  import frr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       read_hit,
  output logic [7:0] status_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= 8'h00;
    end else if (load) begin
      status_q <= load_val;
    end else if (read_hit) begin
      status_q <= status_q ^ TOGGLE_MASK;
    end
  end

  // R7: a status read without a load flips only bit 6
  p_toggle_r7: assert property (@(posedge clk) disable iff (rst)
    (read_hit && !load) |=> ((status_q ^ $past(status_q)) == TOGGLE_MASK));

  // R7: no read and no load keeps the status
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!read_hit && !load) |=> $stable(status_q));

  // R8: a load wins over a simultaneous toggle
  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> (status_q == $past(load_val)));

endmodule

// File: rtl/flash_read_resp.sv
module flash_read_resp
  import frr_pkg::*;
#(
  parameter int         BUS_BYTES = 2,
  parameter int         ADDR_W    = 16,
  parameter logic [7:0] QRY_LEN   = 8'h52
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [2:0]             cmd_state,
  input  logic                   big_endian,
  input  logic [15:0]            id_mfr,
  input  logic [15:0]            id_dev,
  input  logic [15:0]            id_ext2,
  input  logic [15:0]            id_ext3,
  input  logic                   st_load,
  input  logic [7:0]             st_load_val,
  output logic [ADDR_W-1:0]      arr_addr,
  input  logic [8*BUS_BYTES-1:0] arr_bytes,
  output logic [7:0]             qry_addr,
  input  logic [7:0]             qry_data,
  output logic [8*BUS_BYTES-1:0] rd_data,
  output logic                   rd_valid,
  output logic                   seq_reset_req
);
  localparam int DW = 8 * BUS_BYTES;

  logic [7:0]    word_idx;
  logic [DW-1:0] array_word;
  rd_src_e       src;
  logic [15:0]   id_val;
  logic          unknown;
  logic [7:0]    status_q;
  logic          status_read;
  logic [31:0]   id_pad;
  logic [31:0]   st_pad;
  logic [31:0]   qry_pad;
  logic [DW-1:0] next_data;

  frr_offset #(.BUS_BYTES(BUS_BYTES), .ADDR_W(ADDR_W)) u_offset (
    .rd_addr  (rd_addr),
    .word_idx (word_idx),
    .word_addr(arr_addr)
  );

  frr_lane_order #(.BUS_BYTES(BUS_BYTES)) u_lanes (
    .lanes     (arr_bytes),
    .big_endian(big_endian),
    .word      (array_word)
  );

  frr_decode #(.QRY_LEN(QRY_LEN)) u_decode (
    .cmd_state(cmd_state),
    .word_idx (word_idx),
    .id_mfr   (id_mfr),
    .id_dev   (id_dev),
    .id_ext2  (id_ext2),
    .id_ext3  (id_ext3),
    .src      (src),
    .id_val   (id_val),
    .unknown  (unknown)
  );

  assign status_read = rd_en && (src == SRC_STATUS);

  frr_status u_status (
    .clk     (clk),
    .rst     (rst),
    .load    (st_load),
    .load_val(st_load_val),
    .read_hit(status_read),
    .status_q(status_q)
  );

  assign qry_addr = word_idx;
  assign id_pad   = {16'h0000, id_val};
  assign st_pad   = {24'h000000, status_q};
  assign qry_pad  = {24'h000000, qry_data};

  always_comb begin
    case (src)
      SRC_ID:     next_data = id_pad[DW-1:0];
      SRC_ZERO:   next_data = '0;
      SRC_STATUS: next_data = st_pad[DW-1:0];
      SRC_QUERY:  next_data = qry_pad[DW-1:0];
      default:    next_data = array_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data       <= '0;
      rd_valid      <= 1'b0;
      seq_reset_req <= 1'b0;
    end else begin
      rd_valid      <= rd_en;
      seq_reset_req <= rd_en && unknown;
      if (rd_en) begin
        rd_data <= next_data;
      end
    end
  end

  // R1: data follows the strobe by one cycle
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R1: without a strobe the output holds
  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (!rd_valid && $stable(rd_data)));

  // R5: protection index reads as zero
  p_prot_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cmd_state == CS_AUTOSEL && word_idx == IDX_PROT) |=> (rd_data == '0));

  // R7: status reads return the pre-toggle status byte
  p_status_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (cmd_state == CS_PROGRAM || cmd_state == CS_CHIP_ERASE ||
               cmd_state == CS_SECTOR_ERASE))
    |=> (rd_data == DW'($past(status_q))));

  // R9: indices past the table read as zero
  p_qry_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cmd_state == CS_QUERY && word_idx > QRY_LEN) |=> (rd_data == '0));

  // R10: an unrecognised code raises the reset request
  p_unknown_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cmd_state == 3'd7) |=> seq_reset_req);

  // R10: the request only accompanies valid data
  p_req_valid_r10: assert property (@(posedge clk) disable iff (rst)
    seq_reset_req |-> rd_valid);

  // R11: outputs are cleared after reset
  p_reset_r11: assert property (@(posedge clk)
    rst |=> (!rd_valid && !seq_reset_req && rd_data == '0));

endmodule

// File: tb/flash_read_resp_tb.sv
module flash_read_resp_tb;
  localparam int BB = 2;
  localparam int AW = 16;
  localparam int DW = 8 * BB;
  localparam int NV = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [2:0]    cmd_state = 3'd0;
  logic          big_endian = 1'b0;
  logic [15:0]   id_mfr  = 16'h0001;
  logic [15:0]   id_dev  = 16'h227E;
  logic [15:0]   id_ext2 = 16'h2210;
  logic [15:0]   id_ext3 = 16'h00FF;
  logic          st_load = 1'b0;
  logic [7:0]    st_load_val = 8'h00;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_bytes;
  logic [7:0]    qry_addr;
  logic [7:0]    qry_data;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic          seq_reset_req;

  int n_vec  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  // Array model: byte at address a is a[7:0] ^ 0xA5
  always_comb begin
    for (int i = 0; i < BB; i++) arr_bytes[8*i +: 8] = (arr_addr[7:0] + 8'(i)) ^ 8'hA5;
  end
  // Query table model: byte at index o is o ^ 0x3C
  assign qry_data = qry_addr ^ 8'h3C;

  flash_read_resp u_dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .cmd_state(cmd_state), .big_endian(big_endian),
    .id_mfr(id_mfr), .id_dev(id_dev), .id_ext2(id_ext2), .id_ext3(id_ext3),
    .st_load(st_load), .st_load_val(st_load_val),
    .arr_addr(arr_addr), .arr_bytes(arr_bytes),
    .qry_addr(qry_addr), .qry_data(qry_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .seq_reset_req(seq_reset_req)
  );

  // {cmd, addr, big_endian, expected}
  localparam logic [35:0] VEC [NV] = '{
    {3'd0, 16'h0010, 1'b0, 16'hB4B5},  // R3 R4 read, little-endian
    {3'd0, 16'h0010, 1'b1, 16'hB5B4},  // R4 big-endian
    {3'd1, 16'h0120, 1'b0, 16'h8485},  // R3 erase setup reads array
    {3'd2, 16'h0000, 1'b0, 16'h0001},  // R5 manufacturer
    {3'd2, 16'h0002, 1'b0, 16'h227E},  // R5 device
    {3'd2, 16'h0004, 1'b0, 16'h0000},  // R5 protection
    {3'd2, 16'h001C, 1'b0, 16'h2210},  // R6 R2 ext2
    {3'd2, 16'h001E, 1'b0, 16'hBABB},  // R6 ext3 low byte FF -> array
    {3'd2, 16'h0008, 1'b0, 16'hACAD},  // R6 other index -> array
    {3'd6, 16'h0020, 1'b0, 16'h002C},  // R9 query index 0x10
    {3'd6, 16'h00A4, 1'b0, 16'h006E},  // R9 index equal to length
    {3'd6, 16'h00A6, 1'b0, 16'h0000},  // R9 index past length
    {3'd6, 16'h01FE, 1'b0, 16'h0000},  // R9 R2 upper bits ignored
    {3'd7, 16'h0010, 1'b0, 16'hB4B5}   // R10 unknown code -> array
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_read(input logic [2:0] c, input logic [15:0] a, input logic be);
    @(negedge clk);
    cmd_state  = c;
    rd_addr    = a;
    big_endian = be;
    rd_en      = 1'b1;
    @(negedge clk);
    rd_en      = 1'b0;
  endtask

  task automatic do_load(input logic [7:0] v);
    @(negedge clk);
    st_load     = 1'b1;
    st_load_val = v;
    @(negedge clk);
    st_load     = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 rd_data in reset", 32'(rd_data), 32'h0);
    check("R11 rd_valid in reset", 32'(rd_valid), 32'h0);
    check("R11 seq_reset_req in reset", 32'(seq_reset_req), 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      do_read(VEC[i][35:33], VEC[i][32:17], VEC[i][16]);
      check($sformatf("vector %0d data", i), 32'(rd_data), 32'(VEC[i][15:0]));
      check("R1 rd_valid", 32'(rd_valid), 32'h1);
      check("R10 seq_reset_req", 32'(seq_reset_req), (VEC[i][35:33] == 3'd7) ? 32'h1 : 32'h0);
    end

    // R1: idle cycle drops valid and holds data
    @(negedge clk);
    check("R1 idle valid", 32'(rd_valid), 32'h0);
    check("R1 idle hold", 32'(rd_data), 32'hB4B5);
    check("R10 request clears", 32'(seq_reset_req), 32'h0);

    // R7 R11: status starts at zero and toggles bit 6 per read
    do_read(3'd3, 16'h0000, 1'b0);
    check("R7 R11 first status", 32'(rd_data), 32'h0000);
    do_read(3'd3, 16'h0000, 1'b0);
    check("R7 toggled status", 32'(rd_data), 32'h0040);

    // R8: load then poll in each status state
    do_load(8'h80);
    do_read(3'd5, 16'h0000, 1'b0);
    check("R8 loaded status", 32'(rd_data), 32'h0080);
    do_read(3'd4, 16'h0000, 1'b0);
    check("R7 chip erase status", 32'(rd_data), 32'h00C0);
    do_read(3'd2, 16'h0000, 1'b0);
    check("R7 id read between polls", 32'(rd_data), 32'h0001);
    do_read(3'd0, 16'h0010, 1'b0);
    check("R3 array read between polls", 32'(rd_data), 32'hB4B5);
    do_read(3'd3, 16'h0000, 1'b0);
    check("R7 no toggle from other reads", 32'(rd_data), 32'h0080);

    // R8: load and status read in the same cycle, load wins
    @(negedge clk);
    st_load = 1'b1; st_load_val = 8'h11;
    cmd_state = 3'd3; rd_en = 1'b1;
    @(negedge clk);
    st_load = 1'b0; rd_en = 1'b0;
    check("R8 read during load returns old", 32'(rd_data), 32'h00C0);
    do_read(3'd3, 16'h0000, 1'b0);
    check("R8 load beats toggle", 32'(rd_data), 32'h0011);

    // R2: 0x1C with upper bits set still maps to index 0x0E
    do_read(3'd2, 16'hFF1C, 1'b0);
    check("R2 upper address bits", 32'(rd_data), 32'h2210);

    // R11: reset mid-run clears outputs and status
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R11 reset clears data", 32'(rd_data), 32'h0);
    rst = 1'b0;
    do_read(3'd3, 16'h0000, 1'b0);
    check("R11 status after reset", 32'(rd_data), 32'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule